// File: doc/BRIEF.md
# System-Management Mode Entry/Exit Sequencer

This block runs the state swap that happens when a processor core enters or leaves its system-management mode. When entry is requested, it marks the mode as active, counts the event and updates the NMI masking state. It then snapshots the live register set and writes the snapshot as 32-bit words into a save area. The save area sits at a fixed distance above a relocatable base. Last, it presents the fixed start-up values that the handler code expects.

When resume is requested, it reads the same area back and rebuilds the register set from it. It relocates the base when the saved revision word permits, and it restores the NMI masking that was in force before entry.

The core connects to the block through three interfaces:
- a one-word-at-a-time memory port with a ready handshake;
- two single-cycle request pulses;
- flat register buses.

The register set has 39 slots, indexed as follows:
- Slots 0 to 13 are CR0, CR3, EFLAGS, EIP, EDI, ESI, EBP, ESP, EBX, EDX, ECX, EAX, DR6 and DR7.
- Slot 14 is CR4.
- Slots 15 + 4*s + f hold segment s, in the order ES, CS, SS, DS, FS, GS. The field f is 0 for the selector, 1 for the base, 2 for the limit and 3 for the raw attribute flags.
- Two further memory-only slots follow: 39 is the revision word and 40 is the saved base.

Top module: `smm_seq`

## Requirements
- R1: Every save-area access goes to base + 0x8000 + offset, where the offset depends on the slot:
  - slot k < 14 is at 0x7FFC - 4k;
  - CR4 is at 0x7F14;
  - the selector of segment s is at 0x7FA8 + 4s;
  - segment s has a descriptor block D at 0x7F84 + 12s for s < 3, and at 0x7F2C + 12(s-3) otherwise; its attribute is at D, its limit at D+4 and its base at D+8;
  - the revision word is at 0x7EFC and the saved base at 0x7EF8.
- R2: An accepted entry performs 41 writes in slot order 0..40. Slot 39 carries 0x00020000 and slot 40 carries the current base.
- R3: An accepted entry sets the active flag and increments the event counter. If NMIs were already blocked, it sets the inside-NMI flag; otherwise it sets the NMI-blocked flag.
- R4: After entry, the register outputs hold the following values:
  - EIP is 0x00008000 and DR7 is 0x00000400;
  - CR4 is 0;
  - CR0 has bits 0, 2, 3 and 31 cleared;
  - CS has selector (base >> 4) & 0xFFFF, base equal to the base and limit 0xFFFFFFFF;
  - every other segment has selector 0, base 0 and limit 0xFFFFFFFF;
  - all remaining slots, attributes included, keep their snapshot values.
- R5: A selector is written as its value & 0xFFFF and is restored as the read word & 0xFFFF. An attribute is written as (flags >> 8) & 0xF0FF and is restored as (word & 0xF0FF) << 8.
- R6: An accepted resume reads slots 0..39 in order and restores slots 0..38 from them. It reads slot 40 and loads it as the new base only when bit 17 of the revision word is 1; otherwise it makes 40 reads and the base is unchanged.
- R7: At the end of a resume, the NMI-blocked flag is cleared only if the inside-NMI flag was clear. The inside-NMI flag and the active flag are always cleared.
- R8: The matching done output, together with the register write strobe, is high for exactly the one cycle after the cycle in which the final access saw ready.
- R9: An entry request while active, or a resume request while inactive, starts no memory access. It leaves the flags unchanged and raises the error strobe for one cycle in the next cycle.
- R10: Entry clears EFLAGS bits 0, 2, 4, 6, 7, 10 and 11 and keeps all other bits. Resume restores the full saved EFLAGS word.
- R11: Write enable and read enable are never high together. Address, write data and the enable stay constant until ready is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enterReq | input | 1 | Entry request pulse |
| resumeReq | input | 1 | Resume request pulse |
| nmiSet | input | 1 | NMI delivered: set the blocked flag |
| nmiClr | input | 1 | NMI return: clear the blocked flag |
| memRdata | input | 32 | Read data, valid with memRdy |
| memRdy | input | 1 | Access completes in this cycle |
| archIn | input | 39x32 | Live register slots, captured on entry acceptance |
| memAddr | output | 32 | Access address |
| memWdata | output | 32 | Write data |
| memWe | output | 1 | Write access pending |
| memRe | output | 1 | Read access pending |
| enterDone | output | 1 | Entry finished |
| resumeDone | output | 1 | Resume finished |
| errStrobe | output | 1 | Request rejected |
| archOut | output | 39x32 | Register slots to load into the core |
| archWe | output | 1 | Load archOut into the core |
| smmActive | output | 1 | Mode active flag |
| nmiBlocked | output | 1 | NMI-blocked flag |
| smmInNmi | output | 1 | Entry happened while NMIs were blocked |
| smiCount | output | CNT_W | Entry event counter |
| smbaseOut | output | 32 | Current save base |

## Verification
The bench first targets NMI nesting. It enters once with NMIs free and once with NMIs already blocked. A design that clears the blocked flag unconditionally on resume would unmask an NMI that was still being serviced.

It resumes once with the relocation bit set and once with it clear. A design that ignores the bit would either miss the 41st read or fetch a stale base. Because the second entry runs at the relocated base, any address arithmetic that held on to the old base shows up as wrong addresses.

Ready is stretched for varying numbers of cycles. This exposes a sequencer that advances or changes its address without ready, or that places the done pulse off by a cycle.

// File: rtl/smm_seq_pkg.sv
package smm_seq_pkg;

  localparam int WORD_W    = 32;
  localparam int GP_N      = 14;
  localparam int CR4_SLOT  = 14;
  localparam int SEG_N     = 6;
  localparam int FLD_N     = 4;
  localparam int SEG_FIRST = 15;
  localparam int ARCH_N    = SEG_FIRST + SEG_N * FLD_N;
  localparam int REV_SLOT  = ARCH_N;
  localparam int BASE_SLOT = ARCH_N + 1;
  localparam int SLOT_N    = ARCH_N + 2;
  localparam int IDX_W     = $clog2(SLOT_N);

  localparam int CR0_SLOT  = 0;
  localparam int EFL_SLOT  = 2;
  localparam int EIP_SLOT  = 3;
  localparam int DR7_SLOT  = 13;
  localparam int CS_SEG    = 1;
  localparam int LOW_SEGS  = 3;

  localparam int FLD_SEL   = 0;
  localparam int FLD_BASE  = 1;
  localparam int FLD_LIM   = 2;
  localparam int FLD_ATTR  = 3;

  localparam int RELOC_BIT = 17;

  localparam logic [WORD_W-1:0] REV_WORD   = 32'h0002_0000;
  localparam logic [WORD_W-1:0] AREA_BIAS  = 32'h0000_8000;
  localparam logic [WORD_W-1:0] ENTRY_EIP  = 32'h0000_8000;
  localparam logic [WORD_W-1:0] ENTRY_DR7  = 32'h0000_0400;
  localparam logic [WORD_W-1:0] CR0_KEEP   = 32'h7FFF_FFF2;
  localparam logic [WORD_W-1:0] EFL_CLR    = 32'h0000_0CD5;
  localparam logic [WORD_W-1:0] ATTR_MASK  = 32'h0000_F0FF;
  localparam logic [WORD_W-1:0] SEL_MASK   = 32'h0000_FFFF;
  localparam logic [WORD_W-1:0] FLAT_LIMIT = 32'hFFFF_FFFF;

  typedef struct packed {
    logic snapIn;
    logic applyEntry;
    logic enterFlags;
    logic restoreWr;
    logic baseWr;
    logic resumeFlags;
  } smm_strobe_t;

  function automatic bit isSegSlot(int slot);
    return (slot >= SEG_FIRST) && (slot < ARCH_N);
  endfunction

  function automatic int segOf(int slot);
    return (slot - SEG_FIRST) / FLD_N;
  endfunction

  function automatic int fieldOf(int slot);
    return (slot - SEG_FIRST) % FLD_N;
  endfunction

  function automatic logic [15:0] slotOffset(int slot);
    int off;
    int blk;
    off = 0;
    blk = 0;
    if (slot < GP_N) begin
      off = 'h7FFC - 4 * slot;
    end else if (slot == CR4_SLOT) begin
      off = 'h7F14;
    end else if (isSegSlot(slot)) begin
      blk = (segOf(slot) < LOW_SEGS) ? ('h7F84 + 12 * segOf(slot))
                                     : ('h7F2C + 12 * (segOf(slot) - LOW_SEGS));
      case (fieldOf(slot))
        FLD_SEL:  off = 'h7FA8 + 4 * segOf(slot);
        FLD_BASE: off = blk + 8;
        FLD_LIM:  off = blk + 4;
        default:  off = blk;
      endcase
    end else if (slot == REV_SLOT) begin
      off = 'h7EFC;
    end else begin
      off = 'h7EF8;
    end
    return 16'(off);
  endfunction

  function automatic logic [WORD_W-1:0] saveWord(int slot, logic [WORD_W-1:0] v);
    if (isSegSlot(slot) && fieldOf(slot) == FLD_SEL) return v & SEL_MASK;
    if (isSegSlot(slot) && fieldOf(slot) == FLD_ATTR) return (v >> 8) & ATTR_MASK;
    return v;
  endfunction

  function automatic logic [WORD_W-1:0] restoreWord(int slot, logic [WORD_W-1:0] w);
    if (isSegSlot(slot) && fieldOf(slot) == FLD_SEL) return w & SEL_MASK;
    if (isSegSlot(slot) && fieldOf(slot) == FLD_ATTR) return (w & ATTR_MASK) << 8;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] entryWord(int slot, logic [WORD_W-1:0] v,
                                                  logic [WORD_W-1:0] base);
    if (slot == CR0_SLOT) return v & CR0_KEEP;
    if (slot == EFL_SLOT) return v & ~EFL_CLR;
    if (slot == EIP_SLOT) return ENTRY_EIP;
    if (slot == DR7_SLOT) return ENTRY_DR7;
    if (slot == CR4_SLOT) return '0;
    if (isSegSlot(slot)) begin
      if (fieldOf(slot) == FLD_ATTR) return v;
      if (fieldOf(slot) == FLD_LIM) return FLAT_LIMIT;
      if (segOf(slot) == CS_SEG) begin
        if (fieldOf(slot) == FLD_SEL) return (base >> 4) & SEL_MASK;
        return base;
      end
      return '0;
    end
    return v;
  endfunction

endpackage

// File: rtl/smm_seq_ctrl.sv
module smm_seq_ctrl
  import smm_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enterReq,
  input  logic              resumeReq,
  input  logic              smmActive,
  input  logic              relocBit,
  input  logic              memRdy,
  output logic [IDX_W-1:0]  slotIdx,
  output logic              memWe,
  output logic              memRe,
  output logic              enterDone,
  output logic              resumeDone,
  output logic              archWe,
  output logic              errStrobe,
  output smm_strobe_t       strb
);

  typedef enum logic [2:0] {S_IDLE, S_SAVE, S_ENT_FIN, S_LOAD, S_RES_FIN} state_t;

  localparam logic [IDX_W-1:0] REV_IDX  = IDX_W'(REV_SLOT);
  localparam logic [IDX_W-1:0] BASE_IDX = IDX_W'(BASE_SLOT);

  state_t           stQ, stD;
  logic [IDX_W-1:0] idxQ, idxD;
  logic             errQ, errD;

  always_comb begin
    stD  = stQ;
    idxD = idxQ;
    strb = '0;
    errD = 1'b0;
    case (stQ)
      S_IDLE: begin
        errD = (enterReq && smmActive) || (resumeReq && !smmActive);
        if (enterReq && !smmActive) begin
          stD             = S_SAVE;
          idxD            = '0;
          strb.snapIn     = 1'b1;
          strb.enterFlags = 1'b1;
        end else if (resumeReq && smmActive) begin
          stD  = S_LOAD;
          idxD = '0;
        end
      end
      S_SAVE: begin
        if (memRdy) begin
          if (idxQ == BASE_IDX) begin
            stD             = S_ENT_FIN;
            idxD            = '0;
            strb.applyEntry = 1'b1;
          end else begin
            idxD = idxQ + 1'b1;
          end
        end
      end
      S_LOAD: begin
        if (memRdy) begin
          if (idxQ == REV_IDX) begin
            if (relocBit) begin
              idxD = BASE_IDX;
            end else begin
              stD              = S_RES_FIN;
              idxD             = '0;
              strb.resumeFlags = 1'b1;
            end
          end else if (idxQ == BASE_IDX) begin
            stD              = S_RES_FIN;
            idxD             = '0;
            strb.baseWr      = 1'b1;
            strb.resumeFlags = 1'b1;
          end else begin
            strb.restoreWr = 1'b1;
            idxD           = idxQ + 1'b1;
          end
        end
      end
      S_ENT_FIN: stD = S_IDLE;
      S_RES_FIN: stD = S_IDLE;
      default:   stD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ  <= S_IDLE;
      idxQ <= '0;
      errQ <= 1'b0;
    end else begin
      stQ  <= stD;
      idxQ <= idxD;
      errQ <= errD;
    end
  end

  assign slotIdx    = idxQ;
  assign memWe      = (stQ == S_SAVE);
  assign memRe      = (stQ == S_LOAD);
  assign enterDone  = (stQ == S_ENT_FIN);
  assign resumeDone = (stQ == S_RES_FIN);
  assign archWe     = enterDone || resumeDone;
  assign errStrobe  = errQ;

  AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe)); // R11
  AST_ENTER_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    enterDone |-> $past(memWe && memRdy)); // R8
  AST_RESUME_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    resumeDone |-> $past(memRe && memRdy)); // R8
  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (enterDone || resumeDone) |=> !(enterDone || resumeDone)); // R8
  AST_ERR_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    errStrobe |-> $past(stQ == S_IDLE)); // R9

endmodule

// File: rtl/smm_seq_dpath.sv
module smm_seq_dpath
  import smm_seq_pkg::*;
#(
  parameter logic [31:0] SMBASE_RST = 32'h0003_0000,
  parameter int          CNT_W      = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  smm_strobe_t                   strb,
  input  logic [IDX_W-1:0]              slotIdx,
  input  logic                          nmiSet,
  input  logic                          nmiClr,
  input  logic [WORD_W-1:0]             memRdata,
  input  logic [ARCH_N-1:0][WORD_W-1:0] archIn,
  output logic [WORD_W-1:0]             memAddr,
  output logic [WORD_W-1:0]             memWdata,
  output logic [ARCH_N-1:0][WORD_W-1:0] archOut,
  output logic                          smmActive,
  output logic                          nmiBlocked,
  output logic                          smmInNmi,
  output logic [CNT_W-1:0]              smiCount,
  output logic [WORD_W-1:0]             smbaseOut
);

  localparam logic [IDX_W-1:0] REV_IDX  = IDX_W'(REV_SLOT);
  localparam logic [IDX_W-1:0] BASE_IDX = IDX_W'(BASE_SLOT);

  logic [ARCH_N-1:0][WORD_W-1:0] bankQ, bankD;
  logic [WORD_W-1:0]             baseQ;
  logic                          activeQ, blockQ, inNmiQ;
  logic [CNT_W-1:0]              cntQ;

  for (genvar g = 0; g < ARCH_N; g++) begin : gSlot
    assign bankD[g] =
      strb.snapIn     ? archIn[g] :
      strb.applyEntry ? entryWord(g, bankQ[g], baseQ) :
      (strb.restoreWr && slotIdx == IDX_W'(g)) ? restoreWord(g, memRdata) :
      bankQ[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ <= '0;
      baseQ <= SMBASE_RST;
    end else begin
      bankQ <= bankD;
      if (strb.baseWr) baseQ <= memRdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      blockQ  <= 1'b0;
      inNmiQ  <= 1'b0;
      cntQ    <= '0;
    end else if (strb.enterFlags) begin
      activeQ <= 1'b1;
      cntQ    <= cntQ + 1'b1;
      if (blockQ) inNmiQ <= 1'b1;
      else        blockQ <= 1'b1;
    end else if (strb.resumeFlags) begin
      activeQ <= 1'b0;
      inNmiQ  <= 1'b0;
      if (!inNmiQ) blockQ <= 1'b0;
    end else if (nmiSet) begin
      blockQ <= 1'b1;
    end else if (nmiClr) begin
      blockQ <= 1'b0;
    end
  end

  assign memAddr = baseQ + AREA_BIAS + {16'h0000, slotOffset(int'(slotIdx))};

  always_comb begin
    if (slotIdx == REV_IDX)       memWdata = REV_WORD;
    else if (slotIdx == BASE_IDX) memWdata = baseQ;
    else                          memWdata = saveWord(int'(slotIdx), bankQ[slotIdx]);
  end

  assign archOut    = bankQ;
  assign smmActive  = activeQ;
  assign nmiBlocked = blockQ;
  assign smmInNmi   = inNmiQ;
  assign smiCount   = cntQ;
  assign smbaseOut  = baseQ;

  AST_ENTER_SETS_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    strb.enterFlags |=> smmActive && nmiBlocked); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.enterFlags |=> smiCount == $past(smiCount) + CNT_W'(1)); // R3
  AST_NESTED_KEEPS_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (strb.resumeFlags && smmInNmi) |=> nmiBlocked && !smmInNmi); // R7
  AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.resumeFlags |=> !smmActive && !smmInNmi); // R7
  AST_BASE_ONLY_ON_RELOC: assert property (@(posedge clk) disable iff (!rstN)
    !strb.baseWr |=> smbaseOut == $past(smbaseOut)); // R6

endmodule

// File: rtl/smm_seq.sv
module smm_seq
  import smm_seq_pkg::*;
#(
  parameter logic [31:0] SMBASE_RST = 32'h0003_0000,
  parameter int          CNT_W      = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          enterReq,
  input  logic                          resumeReq,
  input  logic                          nmiSet,
  input  logic                          nmiClr,
  input  logic [WORD_W-1:0]             memRdata,
  input  logic                          memRdy,
  input  logic [ARCH_N-1:0][WORD_W-1:0] archIn,
  output logic [WORD_W-1:0]             memAddr,
  output logic [WORD_W-1:0]             memWdata,
  output logic                          memWe,
  output logic                          memRe,
  output logic                          enterDone,
  output logic                          resumeDone,
  output logic                          errStrobe,
  output logic [ARCH_N-1:0][WORD_W-1:0] archOut,
  output logic                          archWe,
  output logic                          smmActive,
  output logic                          nmiBlocked,
  output logic                          smmInNmi,
  output logic [CNT_W-1:0]              smiCount,
  output logic [WORD_W-1:0]             smbaseOut
);

  smm_strobe_t      strb;
  logic [IDX_W-1:0] slotIdx;

  smm_seq_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .enterReq   (enterReq),
    .resumeReq  (resumeReq),
    .smmActive  (smmActive),
    .relocBit   (memRdata[RELOC_BIT]),
    .memRdy     (memRdy),
    .slotIdx    (slotIdx),
    .memWe      (memWe),
    .memRe      (memRe),
    .enterDone  (enterDone),
    .resumeDone (resumeDone),
    .archWe     (archWe),
    .errStrobe  (errStrobe),
    .strb       (strb)
  );

  smm_seq_dpath #(
    .SMBASE_RST (SMBASE_RST),
    .CNT_W      (CNT_W)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .slotIdx    (slotIdx),
    .nmiSet     (nmiSet),
    .nmiClr     (nmiClr),
    .memRdata   (memRdata),
    .archIn     (archIn),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .archOut    (archOut),
    .smmActive  (smmActive),
    .nmiBlocked (nmiBlocked),
    .smmInNmi   (smmInNmi),
    .smiCount   (smiCount),
    .smbaseOut  (smbaseOut)
  );

  AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !memRdy) |=> memWe && $stable(memAddr) && $stable(memWdata)); // R11
  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memRe && !memRdy) |=> memRe && $stable(memAddr)); // R11

endmodule

// File: tb/smm_seq_tb_top.sv
`timescale 1ns/1ps
module smm_seq_tb_top;
  import smm_seq_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, enterReq, resumeReq, nmiSet, nmiClr, memRdy;
  logic [31:0] memRdata, memAddr, memWdata, smbaseOut;
  logic memWe, memRe, enterDone, resumeDone, errStrobe, archWe;
  logic smmActive, nmiBlocked, smmInNmi;
  logic [31:0] smiCount;
  logic [ARCH_N-1:0][31:0] archIn, archOut;

  smm_seq dut_i (
    .clk(clk), .rstN(rstN), .enterReq(enterReq), .resumeReq(resumeReq),
    .nmiSet(nmiSet), .nmiClr(nmiClr), .memRdata(memRdata), .memRdy(memRdy),
    .archIn(archIn), .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .memRe(memRe), .enterDone(enterDone), .resumeDone(resumeDone),
    .errStrobe(errStrobe), .archOut(archOut), .archWe(archWe),
    .smmActive(smmActive), .nmiBlocked(nmiBlocked), .smmInNmi(smmInNmi),
    .smiCount(smiCount), .smbaseOut(smbaseOut)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [31:0] data;
  } item_t;
  item_t expQ[$];

  // R1 layout, derived independently from the requirement text
  function automatic logic [31:0] tbOffset(int s);
    int k, sg, fl;
    logic [31:0] blk;
    if (s == 39) return 32'h7EFC;
    if (s == 40) return 32'h7EF8;
    if (s == 14) return 32'h7F14;
    if (s < 14) return 32'h7FFC - 32'(4 * s);
    k = s - 15; sg = k / 4; fl = k % 4;
    blk = (sg < 3) ? 32'h7F84 + 32'(12 * sg) : 32'h7F2C + 32'(12 * (sg - 3));
    case (fl)
      0: return 32'h7FA8 + 32'(4 * sg);
      1: return blk + 32'd8;
      2: return blk + 32'd4;
      default: return blk;
    endcase
  endfunction

  function automatic logic [31:0] tbSave(int s, logic [31:0] v);
    if (s >= 15 && s < 39 && (s - 15) % 4 == 0) return {16'h0, v[15:0]};
    if (s >= 15 && s < 39 && (s - 15) % 4 == 3) return {16'h0, v[23:20], 4'h0, v[15:8]};
    return v;
  endfunction

  function automatic logic [31:0] tbRestore(int s, logic [31:0] w);
    if (s >= 15 && s < 39 && (s - 15) % 4 == 0) return {16'h0, w[15:0]};
    if (s >= 15 && s < 39 && (s - 15) % 4 == 3) return {8'h0, w[15:12], 4'h0, w[7:0], 8'h0};
    return w;
  endfunction

  function automatic logic [31:0] tbEntry(int s, logic [31:0] v, logic [31:0] base);
    int sg, fl;
    case (s)
      0:  return {1'b0, v[30:4], 2'b00, v[1], 1'b0};
      2:  return v & 32'hFFFF_F32A;
      3:  return 32'h0000_8000;
      13: return 32'h0000_0400;
      14: return 32'h0;
      default: ;
    endcase
    if (s < 15) return v;
    sg = (s - 15) / 4; fl = (s - 15) % 4;
    if (fl == 3) return v;
    if (fl == 2) return 32'hFFFF_FFFF;
    if (sg == 1) return (fl == 0) ? {16'h0, base[19:4]} : base;
    return 32'h0;
  endfunction

  // Memory model and scoreboard monitor
  int  waitLeft = 0;
  int  delayCnt = 0;
  bit  pendDone = 0;
  item_t it;

  initial begin
    memRdy = 1'b0;
    memRdata = '0;
    forever begin
      @(negedge clk);
      memRdy = 1'b0;
      if (pendDone) begin
        pendDone = 0;
        check("R8", "done pulse", 32'(enterDone | resumeDone), 32'd1);
        check("R8", "archWe with done", 32'(archWe), 32'd1);
      end
      if (rstN && (memWe || memRe)) begin
        if (expQ.size() == 0) begin
          check("R2", "unexpected access addr", memAddr, 32'hDEAD_DEAD);
        end else if (waitLeft > 0) begin
          waitLeft--;
          check("R11", "held address", memAddr, expQ[0].addr);
          check("R11", "held enable", 32'(memWe), 32'(expQ[0].we));
        end else begin
          it = expQ.pop_front();
          check("R11", "access kind", 32'(memWe), 32'(it.we));
          check("R1", "address", memAddr, it.addr);
          if (it.we) check("R2", "write data", memWdata, it.data);
          else memRdata = it.data;
          memRdy = 1'b1;
          delayCnt++;
          waitLeft = (delayCnt % 5 == 2) ? 2 : ((delayCnt % 7 == 3) ? 1 : 0);
          if (expQ.size() == 0) pendDone = 1;
        end
      end
    end
  end

  logic [31:0] curBase;

  task automatic waitFor(bit ent);
    int n = 0;
    while (!(ent ? enterDone : resumeDone) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check("R8", "done reached", 32'(n < 3000), 32'd1);
  endtask

  task automatic doEnter(logic [31:0] seed);
    for (int s = 0; s < ARCH_N; s++) archIn[s] = seed ^ (32'(s) * 32'h0107_0D13);
    for (int s = 0; s < ARCH_N; s++)
      expQ.push_back('{1'b1, curBase + 32'h8000 + tbOffset(s), tbSave(s, archIn[s])});
    expQ.push_back('{1'b1, curBase + 32'h8000 + tbOffset(39), 32'h0002_0000});
    expQ.push_back('{1'b1, curBase + 32'h8000 + tbOffset(40), curBase});
    @(negedge clk); enterReq = 1'b1;
    @(negedge clk); enterReq = 1'b0;
    waitFor(1'b1);
    check("R2", "all writes consumed", 32'(expQ.size()), 32'd0);
    for (int s = 0; s < ARCH_N; s++)
      check((s == 2) ? "R10" : "R4", $sformatf("entry slot %0d", s), archOut[s],
            tbEntry(s, archIn[s], curBase));
  endtask

  task automatic doResume(logic [31:0] seed, logic [31:0] rev, logic [31:0] newBase);
    logic [31:0] img [ARCH_N];
    for (int s = 0; s < ARCH_N; s++) begin
      img[s] = seed + 32'(s) * 32'h1133_5577;
      expQ.push_back('{1'b0, curBase + 32'h8000 + tbOffset(s), img[s]});
    end
    expQ.push_back('{1'b0, curBase + 32'h8000 + tbOffset(39), rev});
    if (rev[17]) expQ.push_back('{1'b0, curBase + 32'h8000 + tbOffset(40), newBase});
    @(negedge clk); resumeReq = 1'b1;
    @(negedge clk); resumeReq = 1'b0;
    waitFor(1'b0);
    check("R6", "all reads consumed", 32'(expQ.size()), 32'd0);
    for (int s = 0; s < ARCH_N; s++)
      check((s == 2) ? "R10" : ((s >= 15) ? "R5" : "R6"), $sformatf("restore slot %0d", s),
            archOut[s], tbRestore(s, img[s]));
    if (rev[17]) curBase = newBase;
    check("R6", "base after resume", smbaseOut, curBase);
    check("R7", "active cleared", 32'(smmActive), 32'd0);
    check("R7", "inside-NMI cleared", 32'(smmInNmi), 32'd0);
  endtask

  task automatic badRequest(bit ent, logic expActive);
    @(negedge clk);
    if (ent) enterReq = 1'b1; else resumeReq = 1'b1;
    @(negedge clk);
    enterReq = 1'b0; resumeReq = 1'b0;
    check("R9", "error strobe", 32'(errStrobe), 32'd1);
    check("R9", "no access started", 32'(memWe | memRe), 32'd0);
    @(negedge clk);
    check("R9", "error strobe one cycle", 32'(errStrobe), 32'd0);
    check("R9", "active unchanged", 32'(smmActive), 32'(expActive));
  endtask

  initial begin
    rstN = 1'b0; enterReq = 1'b0; resumeReq = 1'b0; nmiSet = 1'b0; nmiClr = 1'b0;
    archIn = '0;
    curBase = 32'h0003_0000;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R3", "reset active", 32'(smmActive), 32'd0);
    check("R3", "reset count", smiCount, 32'd0);
    check("R6", "reset base", smbaseOut, 32'h0003_0000);
    check("R11", "reset idle port", 32'(memWe | memRe), 32'd0);

    badRequest(1'b0, 1'b0);

    doEnter(32'hA5C3_19F0);
    check("R3", "active after entry", 32'(smmActive), 32'd1);
    check("R3", "count after entry", smiCount, 32'd1);
    check("R3", "NMI blocked after entry", 32'(nmiBlocked), 32'd1);
    check("R3", "not inside NMI", 32'(smmInNmi), 32'd0);

    badRequest(1'b1, 1'b1);
    check("R9", "count unchanged", smiCount, 32'd1);

    doResume(32'h0F1E_2D3C, 32'h0002_0000, 32'h0005_0000);
    check("R7", "NMI unblocked", 32'(nmiBlocked), 32'd0);

    @(negedge clk); nmiSet = 1'b1;
    @(negedge clk); nmiSet = 1'b0;
    check("R3", "NMI preset", 32'(nmiBlocked), 32'd1);

    doEnter(32'h5A3C_E607);
    check("R3", "count second entry", smiCount, 32'd2);
    check("R3", "inside NMI set", 32'(smmInNmi), 32'd1);
    check("R3", "still blocked", 32'(nmiBlocked), 32'd1);

    doResume(32'hC0DE_F00D, 32'h0001_0000, 32'h0007_0000);
    check("R7", "NMI kept blocked", 32'(nmiBlocked), 32'd1);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule